// File: doc/BRIEF.md
# Memory-Mapped Keyboard Receiver

This block connects a keyboard to a 16-bit processor as two words in its address space: a status word and a character word. The keyboard side offers a one-cycle strobe with an 8-bit character code. The block keeps that code and raises a ready flag. After that it ignores the keyboard until software has taken the character by reading the character word.

Software can poll the ready flag. It can also set an interrupt-enable flag in the status word. The interrupt request line is then high whenever a character is waiting and the enable flag is set. The processor bus has an address, a read strobe, a write strobe and write data. Read data is combinational and is valid in the cycle of the read strobe. Any side effect of an access takes place at the clock edge that ends that cycle.

Top module: `kbd_in_port`

## Requirements
- R1: A key strobe accepted while ready is clear stores the 8-bit code and sets ready (status bit 15) at the next clock edge.
- R2: A read of the character word at 0xFE02 returns the stored code in bits [7:0] and zero in bits [15:8].
- R3: While ready is set, a key strobe with no character-word read in the same cycle is discarded: the stored code is unchanged and ready stays set.
- R4: A read of the character word clears ready at the clock edge that ends the read, so the next strobe is accepted.
- R5: A write to the status word at 0xFE00 loads only the enable flag (bit 14) from write data bit 14. Ready cannot be written, and every status bit other than 15 and 14 reads as zero.
- R6: The interrupt request is high exactly when ready and enable are both one.
- R7: After synchronous reset, ready, enable and the stored code are all zero, and the interrupt request is low.
- R8: When a key strobe and a character-word read occur in the same cycle while ready is set, the read returns the old code. The new code is then stored and ready is set again.
- R9: A status read has no side effect. Writes to the character word and any access to another address change nothing, and reads of other addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_strobe | input | 1 | One-cycle pulse: a character is offered |
| key_code | input | 8 | Character code offered with the strobe |
| bus_addr | input | 16 | Processor word address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, zero when not reading a mapped word |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters:
- 16-bit address and data.
- 8-bit character codes.
- Status word at 0xFE00 and character word at 0xFE02.

With these values the tests exercise the exact word patterns software would see, such as 0x8000, 0x4000 and 0xC000, and the zero upper byte of the character word. They also reach the lockout, the read that races a new strobe, and the rise and fall of the interrupt around enable writes and character reads.

// File: rtl/kbd_in_pkg.sv
package kbd_in_pkg;

    // Which register, if any, the current bus access selects
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CHAR = 2'd2
    } reg_sel_t;

    // Decoded access strobes
    typedef struct packed {
        logic stat_rd;
        logic stat_wr;
        logic char_rd;
        logic char_wr;
    } bus_hit_t;

    // Place a single flag at a given bit of a zeroed word
    function automatic logic [15:0] flag_at(input logic val, input int pos);
        logic [15:0] w;
        w = '0;
        w[pos] = val;
        return w;
    endfunction

endpackage

// File: rtl/kbd_in_decode.sv
module kbd_in_decode
    import kbd_in_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE00,
    parameter logic [ADDR_W-1:0] CHAR_ADDR = 16'hFE02
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output reg_sel_t          sel,
    output bus_hit_t          hit
);
    always_comb begin
        if (addr == STAT_ADDR)      sel = SEL_STAT;
        else if (addr == CHAR_ADDR) sel = SEL_CHAR;
        else                        sel = SEL_NONE;
    end

    always_comb begin
        hit         = '0;
        hit.stat_rd = rd && (sel == SEL_STAT);
        hit.stat_wr = wr && (sel == SEL_STAT);
        hit.char_rd = rd && (sel == SEL_CHAR);
        hit.char_wr = wr && (sel == SEL_CHAR);
    end
endmodule

// File: rtl/kbd_in_char_reg.sv
module kbd_in_char_reg #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              key_strobe,
    input  logic [CHAR_W-1:0] key_code,
    input  logic              char_rd,
    output logic              rdy,
    output logic [CHAR_W-1:0] char_q
);
    logic accept;

    // A read in the same cycle frees the slot before the new code lands
    assign accept = key_strobe && (!rdy || char_rd);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy    <= 1'b0;
            char_q <= '0;
        end else if (accept) begin
            rdy    <= 1'b1;
            char_q <= key_code;
        end else if (char_rd) begin
            rdy    <= 1'b0;
        end
    end
endmodule

// File: rtl/kbd_in_ctrl_reg.sv
module kbd_in_ctrl_reg (
    input  logic clk,
    input  logic rst,
    input  logic stat_wr,
    input  logic wdata_bit,
    output logic ie
);
    always_ff @(posedge clk) begin
        if (rst)          ie <= 1'b0;
        else if (stat_wr) ie <= wdata_bit;
    end
endmodule

// File: rtl/kbd_in_port.sv
module kbd_in_port
    import kbd_in_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CHAR_W = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE00,
    parameter logic [ADDR_W-1:0] CHAR_ADDR = 16'hFE02
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              key_strobe,
    input  logic [CHAR_W-1:0] key_code,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int RDY_BIT = DATA_W - 1;
    localparam int IE_BIT  = DATA_W - 2;
    localparam int PAD_W   = DATA_W - CHAR_W;

    reg_sel_t          sel;
    bus_hit_t          hit;
    logic              rdy;
    logic              ie;
    logic [CHAR_W-1:0] char_q;
    logic [DATA_W-1:0] stat_word;
    logic [DATA_W-1:0] char_word;

    kbd_in_decode #(
        .ADDR_W   (ADDR_W),
        .STAT_ADDR(STAT_ADDR),
        .CHAR_ADDR(CHAR_ADDR)
    ) u_dec (
        .addr(bus_addr),
        .rd  (bus_rd),
        .wr  (bus_wr),
        .sel (sel),
        .hit (hit)
    );

    kbd_in_char_reg #(.CHAR_W(CHAR_W)) u_char (
        .clk       (clk),
        .rst       (rst),
        .key_strobe(key_strobe),
        .key_code  (key_code),
        .char_rd   (hit.char_rd),
        .rdy       (rdy),
        .char_q    (char_q)
    );

    kbd_in_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .stat_wr  (hit.stat_wr),
        .wdata_bit(bus_wdata[IE_BIT]),
        .ie       (ie)
    );

    // Status word: only the ready and enable flags are populated
    always_comb begin
        stat_word = '0;
        stat_word[RDY_BIT] = rdy;
        stat_word[IE_BIT]  = ie;
    end

    // Character word: code zero-extended into the upper bits
    generate
        if (PAD_W > 0) begin : g_pad
            assign char_word = {{PAD_W{1'b0}}, char_q};
        end else begin : g_nopad
            assign char_word = char_q[DATA_W-1:0];
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (sel)
                SEL_STAT: bus_rdata = stat_word;
                SEL_CHAR: bus_rdata = char_word;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign irq = rdy && ie;
endmodule

// File: rtl/kbd_in_chk.sv
module kbd_in_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CHAR_W = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE00,
    parameter logic [ADDR_W-1:0] CHAR_ADDR = 16'hFE02
) (
    input logic              clk,
    input logic              rst,
    input logic              key_strobe,
    input logic [CHAR_W-1:0] key_code,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic              rdy,
    input logic              ie,
    input logic [CHAR_W-1:0] char_q
);
    logic cr;
    logic sw;
    assign cr = bus_rd && (bus_addr == CHAR_ADDR);
    assign sw = bus_wr && (bus_addr == STAT_ADDR);

    // R1
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (key_strobe && !rdy) |=> (rdy && char_q == $past(key_code)));

    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        cr |-> (bus_rdata[DATA_W-1:CHAR_W] == '0));

    // R3
    lockout_chk: assert property (@(posedge clk) disable iff (rst)
        (rdy && key_strobe && !cr) |=> (rdy && $stable(char_q)));

    // R4
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cr && !key_strobe) |=> !rdy);

    // R5
    ie_write_chk: assert property (@(posedge clk) disable iff (rst)
        sw |=> (ie == $past(bus_wdata[DATA_W-2])));

    // R6
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(key_strobe || sw));

    // R8
    race_chk: assert property (@(posedge clk) disable iff (rst)
        (rdy && key_strobe && cr) |=> (rdy && char_q == $past(key_code)));
endmodule

bind kbd_in_port kbd_in_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W),
    .STAT_ADDR(STAT_ADDR), .CHAR_ADDR(CHAR_ADDR)
) u_chk (
    .clk(clk), .rst(rst), .key_strobe(key_strobe), .key_code(key_code),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .rdy(rdy), .ie(ie), .char_q(char_q)
);

// File: tb/kbd_in_port_bench.sv
module kbd_in_port_bench;
    localparam logic [15:0] STAT = 16'hFE00;
    localparam logic [15:0] CHR  = 16'hFE02;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        key_strobe = 1'b0;
    logic [7:0]  key_code = '0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    kbd_in_port u_kbd_in_port (
        .clk(clk), .rst(rst), .key_strobe(key_strobe), .key_code(key_code),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic send_key(input logic [7:0] c);
        @(negedge clk);
        key_code = c; key_strobe = 1'b1;
        @(negedge clk);
        key_strobe = 1'b0;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        bus_read(STAT, v); check("R7 status after reset", v, 16'h0000);
        bus_read(CHR, v);  check("R7 char after reset", v, 16'h0000);
        check("R7 irq after reset", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_accept_lockout;
        logic [15:0] v;
        send_key(8'h41);
        bus_read(STAT, v); check("R1 ready set", v, 16'h8000);
        bus_read(STAT, v); check("R9 status read no side effect", v, 16'h8000);
        send_key(8'h42);
        bus_read(STAT, v); check("R3 still ready", v, 16'h8000);
        bus_read(CHR, v);  check("R2 R3 old code kept, upper zero", v, 16'h0041);
        bus_read(STAT, v); check("R4 ready cleared by read", v, 16'h0000);
        send_key(8'hC3);
        bus_read(CHR, v);  check("R4 R2 next code accepted", v, 16'h00C3);
    endtask

    task automatic t_enable_irq;
        logic [15:0] v;
        bus_write(STAT, 16'hFFFF);
        bus_read(STAT, v); check("R5 only enable written", v, 16'h4000);
        check("R6 irq low without ready", {15'd0, irq}, 16'h0000);
        send_key(8'h5A);
        #1 check("R6 irq high", {15'd0, irq}, 16'h0001);
        bus_read(STAT, v); check("R5 R6 status both flags", v, 16'hC000);
        bus_write(STAT, 16'hBFFF);
        #1 check("R6 irq low after disable", {15'd0, irq}, 16'h0000);
        bus_read(STAT, v); check("R5 ready unchanged by write", v, 16'h8000);
        bus_write(STAT, 16'h4000);
        #1 check("R6 irq high after enable", {15'd0, irq}, 16'h0001);
        bus_read(CHR, v);  check("R2 code", v, 16'h005A);
        #1 check("R6 irq low after read", {15'd0, irq}, 16'h0000);
        bus_write(STAT, 16'h0000);
    endtask

    task automatic t_race;
        logic [15:0] v;
        send_key(8'h11);
        @(negedge clk);
        bus_addr = CHR; bus_rd = 1'b1; key_code = 8'h22; key_strobe = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; key_strobe = 1'b0;
        check("R8 read returns old code", v, 16'h0011);
        bus_read(STAT, v); check("R8 ready set again", v, 16'h8000);
        bus_read(CHR, v);  check("R8 new code stored", v, 16'h0022);
    endtask

    task automatic t_ignored;
        logic [15:0] v;
        send_key(8'h66);
        bus_write(CHR, 16'h1234);
        bus_write(16'hFE04, 16'hFFFF);
        bus_read(16'hFE04, v); check("R9 unmapped read zero", v, 16'h0000);
        bus_read(STAT, v); check("R9 status unchanged", v, 16'h8000);
        bus_read(CHR, v);  check("R9 char write ignored", v, 16'h0066);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_accept_lockout();
        t_enable_irq();
        t_race();
        t_ignored();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule